// File: doc/BRIEF.md
# Wormhole Output Port Controller

This block runs one output port of a wormhole router that offers two service levels. A packet sent with the single service level gets the port for one flit at a time: every flit needs a fresh grant from the allocator. A packet sent with the block service level keeps the port once its head flit is granted. The controller loads the body-flit count carried by the head flit. It then forwards body flits from the same source, with no further arbitration, until that count is spent.

The allocator supplies a grant and an input index with the granted head flit's type and count. The controller also sees the empty flags of all input FIFOs and the full flag of the downstream FIFO. A flit moves when its source holds data and the downstream FIFO has room. Every move produces a registered, active-low write strobe and a registered select for the output multiplexer, both valid in the cycle after the decision. A registered reserved flag shows that the port is locked by a block transfer and ignores the allocator. The allocator is expected to use this flag to leave the port out of arbitration.

Top module: `wh_port_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `reserved_o` is 0, `wr_n_o` is 1 and `sel_o` is 0.
- R2: While not reserved, a grant whose source `src_empty_i[sel_i]` is 0, with `dst_full_i` at 0, gives `wr_n_o`=0 and `sel_o`=`sel_i` on the next cycle.
- R3: While `dst_full_i` is 1, no flit moves: `wr_n_o` is 1 on the next cycle, and neither the reserved state nor the remaining count changes.
- R4: A moving head flit with `blk_i`=1 (1 = block level, 0 = single level) and `cnt_i` N greater than 0 sets `reserved_o` to 1 on the next cycle.
- R5: While reserved, `grant_i`, `sel_i`, `blk_i` and `cnt_i` are ignored. `sel_o` holds the index of the head flit's source, and a flit is written whenever that source is not empty and the downstream FIFO is not full.
- R6: The remaining count drops by one only on a cycle in which a body flit moves. A cycle in which the held source is empty writes nothing and does not shorten the reservation.
- R7: The cycle that shows the write of the Nth body flit (`wr_n_o`=0) also shows `reserved_o`=0. A grant in that cycle is served.
- R8: A block-level head flit with `cnt_i`=0 is sent, and `reserved_o` stays 0.
- R9: A single-level head flit never sets `reserved_o`. Without a new grant, no further flit is written.
- R10: While not reserved, a grant whose source is empty writes nothing (`wr_n_o`=1 on the next cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| grant_i | input | 1 | Allocator grants a head flit to this port |
| sel_i | input | SEL_W | Index of the granted input |
| blk_i | input | 1 | Service level of the granted head flit (1 = block) |
| cnt_i | input | CNT_W | Body-flit count from the granted head flit |
| src_empty_i | input | N_IN | Empty flag of each input FIFO |
| dst_full_i | input | 1 | Downstream FIFO full |
| reserved_o | output | 1 | Port locked by a block transfer |
| sel_o | output | SEL_W | Select for the output multiplexer |
| wr_n_o | output | 1 | Active-low downstream write strobe |

## Verification
Every decision is taken from the inputs in one cycle and appears on all three outputs exactly one clock edge later. The bench therefore drives inputs at the falling edge. At the next falling edge it compares the outputs with a model state that it advanced from those same inputs. Directed sequences cover stalls on a full downstream FIFO and on an empty source, grants that arrive during a reservation, the release cycle and zero-length block packets. A seeded random phase then mixes all of these.

// File: rtl/wh_port_pkg.sv
package wh_port_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_BLOCK  = 1'b1
  } port_mode_e;
endpackage

// File: rtl/wh_move_detect.sv
// Decides whether a flit crosses the port in the current cycle.
module wh_move_detect
  import wh_port_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int SEL_W = 2
) (
  input  port_mode_e       mode,
  input  logic [SEL_W-1:0] held_sel,
  input  logic             grant,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [N_IN-1:0]  src_empty,
  input  logic             dst_full,
  output logic             head_move,
  output logic             body_move
);
  logic [SEL_W-1:0] src_sel;
  logic             src_ready;

  always_comb begin
    src_sel   = (mode == MODE_BLOCK) ? held_sel : req_sel;
    src_ready = !src_empty[src_sel] && !dst_full;
    head_move = (mode == MODE_SINGLE) && grant && src_ready;
    body_move = (mode == MODE_BLOCK) && src_ready;
  end
endmodule

// File: rtl/wh_body_counter.sv
// Remaining body flits of the current block transfer.
module wh_body_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)       remain <= '0;
    else if (load) remain <= load_val;
    else if (dec)  remain <= remain - ONE;
  end

  assign last = (remain == ONE);
endmodule

// File: rtl/wh_mode_fsm.sv
// Service-level state of the port: free (single) or reserved (block).
module wh_mode_fsm
  import wh_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       head_move,
  input  logic       head_blk,
  input  logic       head_cnt_nz,
  input  logic       body_move,
  input  logic       last_body,
  output port_mode_e mode,
  output logic       take_block
);
  port_mode_e mode_nx;

  always_comb begin
    take_block = head_move && head_blk && head_cnt_nz;
    mode_nx    = mode;
    unique case (mode)
      MODE_SINGLE: if (take_block) mode_nx = MODE_BLOCK;
      MODE_BLOCK:  if (body_move && last_body) mode_nx = MODE_SINGLE;
      default:     mode_nx = MODE_SINGLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= MODE_SINGLE;
    else     mode <= mode_nx;
  end
endmodule

// File: rtl/wh_port_ctrl.sv
module wh_port_ctrl
  import wh_port_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int CNT_W = 3,
  localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grant_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             blk_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [N_IN-1:0]  src_empty_i,
  input  logic             dst_full_i,
  output logic             reserved_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             wr_n_o
);
  port_mode_e mode;
  logic       head_move, body_move, last_body, take_block;

  wh_move_detect #(.N_IN(N_IN), .SEL_W(SEL_W)) u_move (
    .mode(mode), .held_sel(sel_o), .grant(grant_i), .req_sel(sel_i),
    .src_empty(src_empty_i), .dst_full(dst_full_i),
    .head_move(head_move), .body_move(body_move)
  );

  wh_body_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(take_block), .load_val(cnt_i),
    .dec(body_move), .last(last_body)
  );

  wh_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .head_move(head_move), .head_blk(blk_i),
    .head_cnt_nz(cnt_i != '0), .body_move(body_move), .last_body(last_body),
    .mode(mode), .take_block(take_block)
  );

  assign reserved_o = (mode == MODE_BLOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o  <= '0;
      wr_n_o <= 1'b1;
    end else begin
      wr_n_o <= !(head_move || body_move);
      if (head_move) sel_o <= sel_i;
    end
  end
endmodule

// File: rtl/wh_port_ctrl_chk.sv
module wh_port_ctrl_chk #(
  parameter int N_IN  = 4,
  parameter int CNT_W = 3,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             grant_i,
  input logic [SEL_W-1:0] sel_i,
  input logic             blk_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [N_IN-1:0]  src_empty_i,
  input logic             dst_full_i,
  input logic             reserved_o,
  input logic [SEL_W-1:0] sel_o,
  input logic             wr_n_o
);
  a_r3_full_no_write: assert property (@(posedge clk) disable iff (rst)
    dst_full_i |=> wr_n_o);

  a_r4_block_reserves: assert property (@(posedge clk) disable iff (rst)
    (!reserved_o && grant_i && !src_empty_i[sel_i] && !dst_full_i && blk_i && cnt_i != '0)
    |=> (reserved_o && !wr_n_o));

  a_r5_sel_held: assert property (@(posedge clk) disable iff (rst)
    reserved_o |=> $stable(sel_o));

  a_r7_release_with_write: assert property (@(posedge clk) disable iff (rst)
    $fell(reserved_o) |-> !wr_n_o);

  a_r8_zero_count_free: assert property (@(posedge clk) disable iff (rst)
    (!reserved_o && blk_i && cnt_i == '0) |=> !reserved_o);

  a_r10_empty_no_write: assert property (@(posedge clk) disable iff (rst)
    (!reserved_o && src_empty_i[sel_i]) |=> wr_n_o);
endmodule

bind wh_port_ctrl wh_port_ctrl_chk #(.N_IN(N_IN), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .grant_i(grant_i), .sel_i(sel_i), .blk_i(blk_i),
  .cnt_i(cnt_i), .src_empty_i(src_empty_i), .dst_full_i(dst_full_i),
  .reserved_o(reserved_o), .sel_o(sel_o), .wr_n_o(wr_n_o)
);

// File: tb/wh_port_ctrl_test.sv
module wh_port_ctrl_test;
  localparam int N_IN = 4, CNT_W = 3, SEL_W = 2;

  logic clk = 0, rst = 1;
  logic grant_i = 0, blk_i = 0, dst_full_i = 0;
  logic [SEL_W-1:0] sel_i = '0;
  logic [CNT_W-1:0] cnt_i = '0;
  logic [N_IN-1:0]  src_empty_i = '1;
  logic reserved_o, wr_n_o;
  logic [SEL_W-1:0] sel_o;

  int checks = 0, fails = 0;
  // model state: expected outputs after the most recent stimulus
  logic m_res = 0, m_wrn = 1;
  logic [SEL_W-1:0] m_sel = '0;
  logic [CNT_W-1:0] m_cnt = '0;
  string pend_tag = "R1";

  always #2 clk = ~clk;

  wh_port_ctrl #(.N_IN(N_IN), .CNT_W(CNT_W)) uut (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic moves(input logic g, input logic [SEL_W-1:0] s,
                                 input logic [N_IN-1:0] e, input logic f);
    if (m_res) return !e[m_sel] && !f;
    return g && !e[s] && !f;
  endfunction

  // at falling edge: check outputs from the previous stimulus, apply new one
  task automatic cyc(input string tag, input logic g, input logic [SEL_W-1:0] s,
                     input logic b, input logic [CNT_W-1:0] n,
                     input logic [N_IN-1:0] e, input logic f);
    logic mv;
    @(negedge clk);
    chk(pend_tag, "reserved_o", int'(reserved_o), int'(m_res));
    chk(pend_tag, "wr_n_o", int'(wr_n_o), int'(m_wrn));
    chk(pend_tag, "sel_o", int'(sel_o), int'(m_sel));
    grant_i = g; sel_i = s; blk_i = b; cnt_i = n; src_empty_i = e; dst_full_i = f;
    mv = moves(g, s, e, f);
    if (!m_res && mv) begin
      m_sel = s;
      if (b && n != 0) begin m_res = 1; m_cnt = n; end
    end else if (m_res && mv) begin
      m_cnt = m_cnt - 1;
      if (m_cnt == 0) m_res = 0;
    end
    m_wrn = !mv;
    pend_tag = tag;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state checked at first compare
    cyc("R9",  1, 2, 0, 3, 4'b0000, 0);  // single head from input 2
    cyc("R9",  0, 1, 0, 0, 4'b0000, 0);  // no grant: no write
    cyc("R2",  1, 3, 0, 0, 4'b0000, 0);
    cyc("R10", 1, 1, 1, 2, 4'b0010, 0);  // source 1 empty
    cyc("R3",  1, 1, 1, 2, 4'b0000, 1);  // downstream full
    cyc("R4",  1, 1, 1, 3, 4'b0000, 0);  // block, 3 body flits
    cyc("R5",  1, 2, 0, 0, 4'b0000, 0);  // other grant ignored, body 1
    cyc("R6",  1, 0, 0, 0, 4'b0010, 0);  // held source empty
    cyc("R3",  0, 0, 0, 0, 4'b0000, 1);  // stall on full
    cyc("R6",  0, 3, 0, 0, 4'b0000, 0);  // body 2
    cyc("R7",  1, 3, 0, 0, 4'b0000, 0);  // body 3: release
    cyc("R7",  1, 0, 0, 0, 4'b0000, 0);  // new grant served
    cyc("R8",  1, 2, 1, 0, 4'b0000, 0);  // block with zero count
    cyc("R8",  1, 3, 1, 1, 4'b0000, 0);  // block with one body flit
    cyc("R7",  0, 0, 0, 0, 4'b0000, 0);
    cyc("R1",  0, 0, 0, 0, 4'b1111, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [N_IN-1:0] e;
      e = N_IN'($urandom) & N_IN'($urandom);
      cyc("R6", 1'($urandom_range(0, 3) != 0), SEL_W'($urandom), 1'($urandom),
          CNT_W'($urandom), e, $urandom_range(0, 4) == 0);
    end
    cyc("R6", 0, 0, 0, 0, 4'b1111, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule